// File: doc/BRIEF.md
# Multiload image page loader

This block copies one stored program image into the banked cartridge RAM. A backing store holds several images of 8448 bytes each. Every image has 32 data pages of 256 bytes, followed by a 256-byte header at offset 8192. A load starts when the bus reads the trigger address while the upper address slot is mapped to ROM. The requested load number is the byte that the system presents on `req_num`, which is the content of RAM location 0x80.

The loader scans the images in order and takes the first one whose header byte 5 equals the request. It sums header bytes 0..7 as a header check. For each page it reads the placement descriptor and the checksum seed from the header, then streams the 256 page bytes into the RAM at the target bank and page. After the pages it writes the start address and the control byte into the console RAM. Checksum failures only raise warnings and never stop the load.

The controller is a single state machine:
- IDLE waits for a trigger.
- SCAN reads byte 5 of one header per visit. On a match it goes to HEAD. When the last image misses it goes to FIN, and otherwise it stays in SCAN for the next image.
- HEAD reads bytes 0..7. It goes to DESC, or to TAIL when the page count is zero.
- DESC reads the descriptor of page j and goes to SEED.
- SEED reads the checksum seed of page j and goes to PAGE.
- PAGE streams the 256 bytes. It goes back to DESC for the next page, or to TAIL after the last page.
- TAIL performs three console writes and goes to FIN.
- FIN raises done for one cycle and returns to IDLE.

Top module: `mload_loader`

## Requirements
- R1: A load starts only when `bus_rd` is high, `bus_addr` equals 0x1850 and `upper_rom` is high, all in a cycle when the loader is idle. Any other access is ignored, including a valid trigger while `busy` is high.
- R2: The loaded image is the lowest-numbered image whose header byte 5 equals `req_num`, sampled at the trigger.
- R3: When the 8-bit sum of header bytes 0..7 differs from 0x55, `hdr_warn` is set. The load still completes.
- R4: The number of pages copied is header byte 3, capped at 32.
- R5: Page j comes from image offset j*256, and its descriptor is header byte 16+j. Descriptor bits 1:0 select the bank and bits 4:2 select the page slot. Bits 7:5 are ignored. `ram_addr` is {bank[12:11], slot[10:8], byte offset[7:0]}, and bytes are written in increasing offset order.
- R6: A page whose descriptor names bank 3 is read but never written.
- R7: For each page, the 8-bit sum of its 256 bytes, its descriptor and header byte 64+j should be 0x55. Any page that fails sets `page_warn`, which stays set for the rest of the load.
- R8: After the pages, three console writes occur in this order: 0xFE gets header byte 0, 0xFF gets header byte 1, and 0x80 gets header byte 2.
- R9: When no image matches, the loader finishes with no RAM or console write and sets `not_found`.
- R10: `busy` rises in the cycle after the trigger. For a match at image m with P pages it lasts 2(m+1)+9+261P+4 cycles; with no match it lasts 2N+1 cycles. `done` is high only in the last of those cycles. All flags clear at the trigger and hold after `done`.
- R11: After reset `busy`, `done`, all flags and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 13 | Bus address |
| upper_rom | input | 1 | Upper slot currently mapped to ROM |
| req_num | input | 8 | Requested load number (RAM location 0x80) |
| st_rd | output | 1 | Store read request |
| st_addr | output | 15 | Store byte address |
| st_data | input | 8 | Store data, valid the cycle after `st_rd` |
| ram_we | output | 1 | Banked RAM write strobe |
| ram_addr | output | 13 | Banked RAM address {bank, slot, offset} |
| ram_wdata | output | 8 | Banked RAM write data |
| zp_we | output | 1 | Console RAM write strobe |
| zp_addr | output | 8 | Console RAM address |
| zp_wdata | output | 8 | Console RAM write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| hdr_warn | output | 1 | Header checksum mismatch |
| page_warn | output | 1 | At least one page checksum mismatch |
| not_found | output | 1 | No image carried the requested number |

## Verification
The hardest situation to reach is a second, valid trigger arriving deep inside a long page stream. The bench reaches it by starting a four-page load and re-issuing the trigger with a different request 100 cycles later. The reference model must then show that no extra write and no timing shift follows. The same model also covers two other cases. One is duplicate load numbers, where the header of a later image is edited so that only the first match may win. The other is a page count above 32, which forces the full 32-page stream through descriptors that include the ROM bank.

// File: rtl/mload_pkg.sv
package mload_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int DATA_PAGES = 32;
    localparam int HDR_BASE   = DATA_PAGES * PAGE_BYTES;
    localparam int IMG_BYTES  = HDR_BASE + PAGE_BYTES;
    localparam int HB_COUNT   = 3;
    localparam int HB_LOADNUM = 5;
    localparam int HB_SUMLEN  = 8;
    localparam int HB_DESC    = 16;
    localparam int HB_SEED    = 64;
    localparam int BANK_W     = 2;
    localparam int SLOT_W     = 3;
    localparam logic [7:0] SUM_OK      = 8'h55;
    localparam logic [7:0] ZP_START_LO = 8'hFE;
    localparam logic [7:0] ZP_START_HI = 8'hFF;
    localparam logic [7:0] ZP_CTRL     = 8'h80;
    localparam logic [BANK_W-1:0] ROM_BANK = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_SCAN, S_HEAD, S_DESC, S_SEED, S_PAGE, S_TAIL, S_FIN
    } ld_state_e;
endpackage

// File: rtl/mload_trig.sv
module mload_trig #(
    parameter int AW = 13,
    parameter logic [AW-1:0] HIT = 'h1850
) (
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic          upper_rom,
    input  logic          idle,
    output logic          fire
);
    assign fire = idle && bus_rd && upper_rom && (bus_addr == HIT);
endmodule

// File: rtl/mload_burst.sv
module mload_burst #(
    parameter int AW = 15,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    output logic          rd,
    output logic [AW-1:0] addr,
    output logic          rv,
    output logic [LW-1:0] ridx,
    output logic          last
);
    logic [LW-1:0] cnt;

    assign rd   = (cnt < len);
    assign addr = base + AW'(cnt);
    assign last = rv && (ridx == len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            rv   <= 1'b0;
            ridx <= '0;
        end else if (clear) begin
            cnt  <= '0;
            rv   <= 1'b0;
        end else begin
            rv   <= rd;
            ridx <= cnt;
            if (rd) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mload_loader.sv
module mload_loader
    import mload_pkg::*;
#(
    parameter int NUM_IMAGES = 3,
    parameter int BUS_AW     = 13,
    parameter logic [BUS_AW-1:0] TRIG_ADDR = 'h1850,
    parameter int MAX_PAGES  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic        upper_rom,
    input  logic [7:0]  req_num,
    output logic        st_rd,
    output logic [$clog2(NUM_IMAGES*IMG_BYTES)-1:0] st_addr,
    input  logic [7:0]  st_data,
    output logic        ram_we,
    output logic [BANK_W+SLOT_W+7:0] ram_addr,
    output logic [7:0]  ram_wdata,
    output logic        zp_we,
    output logic [7:0]  zp_addr,
    output logic [7:0]  zp_wdata,
    output logic        busy,
    output logic        done,
    output logic        hdr_warn,
    output logic        page_warn,
    output logic        not_found
);
    localparam int STORE_AW = $clog2(NUM_IMAGES*IMG_BYTES);
    localparam int RAM_AW   = BANK_W + SLOT_W + 8;
    localparam int LEN_W    = $clog2(PAGE_BYTES + 1);
    localparam int IMG_W    = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1;
    localparam int PG_W     = $clog2(MAX_PAGES + 1);

    ld_state_e state, state_n;

    logic [IMG_W-1:0]    img;
    logic [STORE_AW-1:0] img_base;
    logic [7:0]          req_q, h0, h1, h2, h3, hsum, psum, desc;
    logic [PG_W-1:0]     jpg, npg;
    logic [1:0]          tcnt;
    logic                hdr_warn_q, page_warn_q, not_found_q;

    logic                fire, match, last_img, last_page;
    logic [PG_W-1:0]     npg_calc;
    logic [STORE_AW-1:0] b_base, b_addr;
    logic [LEN_W-1:0]    b_len, b_ridx;
    logic                b_rd, b_rv, b_last, b_clear;

    mload_trig #(.AW(BUS_AW), .HIT(TRIG_ADDR)) u_trig (
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .upper_rom(upper_rom),
        .idle     (state == S_IDLE),
        .fire     (fire)
    );

    mload_burst #(.AW(STORE_AW), .LW(LEN_W)) u_burst (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(b_clear),
        .base (b_base),
        .len  (b_len),
        .rd   (b_rd),
        .addr (b_addr),
        .rv   (b_rv),
        .ridx (b_ridx),
        .last (b_last)
    );

    assign match     = (st_data == req_q);
    assign last_img  = (img == IMG_W'(NUM_IMAGES - 1));
    assign npg_calc  = (h3 > 8'(MAX_PAGES)) ? PG_W'(MAX_PAGES) : PG_W'(h3);
    assign last_page = ((jpg + 1'b1) == npg);
    assign b_clear   = b_last || (state_n != state);

    // Read window selected by the current state
    always_comb begin
        b_base = img_base;
        b_len  = '0;
        unique case (state)
            S_SCAN: begin
                b_base = img_base + STORE_AW'(HDR_BASE + HB_LOADNUM);
                b_len  = LEN_W'(1);
            end
            S_HEAD: begin
                b_base = img_base + STORE_AW'(HDR_BASE);
                b_len  = LEN_W'(HB_SUMLEN);
            end
            S_DESC: begin
                b_base = img_base + STORE_AW'(HDR_BASE + HB_DESC) + STORE_AW'(jpg);
                b_len  = LEN_W'(1);
            end
            S_SEED: begin
                b_base = img_base + STORE_AW'(HDR_BASE + HB_SEED) + STORE_AW'(jpg);
                b_len  = LEN_W'(1);
            end
            S_PAGE: begin
                b_base = img_base + STORE_AW'({jpg, 8'h00});
                b_len  = LEN_W'(PAGE_BYTES);
            end
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (fire) state_n = S_SCAN;
            S_SCAN: if (b_last) begin
                if (match)         state_n = S_HEAD;
                else if (last_img) state_n = S_FIN;
            end
            S_HEAD: if (b_last) state_n = (npg_calc == '0) ? S_TAIL : S_DESC;
            S_DESC: if (b_last) state_n = S_SEED;
            S_SEED: if (b_last) state_n = S_PAGE;
            S_PAGE: if (b_last) state_n = last_page ? S_TAIL : S_DESC;
            S_TAIL: if (tcnt == 2'd2) state_n = S_FIN;
            S_FIN:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img <= '0; img_base <= '0; req_q <= '0;
            h0 <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
            hsum <= '0; psum <= '0; desc <= '0;
            jpg <= '0; npg <= '0; tcnt <= '0;
            hdr_warn_q <= 1'b0; page_warn_q <= 1'b0; not_found_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (fire) begin
                    req_q <= req_num;
                    img <= '0; img_base <= '0;
                    jpg <= '0; tcnt <= '0;
                    hdr_warn_q <= 1'b0; page_warn_q <= 1'b0; not_found_q <= 1'b0;
                end
                S_SCAN: if (b_last && !match) begin
                    if (last_img) not_found_q <= 1'b1;
                    else begin
                        img      <= img + 1'b1;
                        img_base <= img_base + STORE_AW'(IMG_BYTES);
                    end
                end
                S_HEAD: if (b_rv) begin
                    hsum <= (b_ridx == '0) ? st_data : hsum + st_data;
                    if (b_ridx == LEN_W'(0)) h0 <= st_data;
                    if (b_ridx == LEN_W'(1)) h1 <= st_data;
                    if (b_ridx == LEN_W'(2)) h2 <= st_data;
                    if (b_ridx == LEN_W'(HB_COUNT)) h3 <= st_data;
                    if (b_last) begin
                        hdr_warn_q <= ((hsum + st_data) != SUM_OK);
                        npg        <= npg_calc;
                    end
                end
                S_DESC: if (b_rv) desc <= st_data;
                S_SEED: if (b_rv) psum <= desc + st_data;
                S_PAGE: if (b_rv) begin
                    psum <= psum + st_data;
                    if (b_last) begin
                        if ((psum + st_data) != SUM_OK) page_warn_q <= 1'b1;
                        jpg <= jpg + 1'b1;
                    end
                end
                S_TAIL: tcnt <= tcnt + 1'b1;
                S_FIN:  ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        st_rd     = b_rd;
        st_addr   = b_addr;
        ram_we    = (state == S_PAGE) && b_rv && (desc[BANK_W-1:0] != ROM_BANK);
        ram_addr  = {desc[BANK_W-1:0], desc[BANK_W+SLOT_W-1:BANK_W], b_ridx[7:0]};
        ram_wdata = st_data;
        zp_we     = (state == S_TAIL);
        unique case (tcnt)
            2'd0:    begin zp_addr = ZP_START_LO; zp_wdata = h0; end
            2'd1:    begin zp_addr = ZP_START_HI; zp_wdata = h1; end
            default: begin zp_addr = ZP_CTRL;     zp_wdata = h2; end
        endcase
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        hdr_warn  = hdr_warn_q;
        page_warn = page_warn_q;
        not_found = not_found_q;
    end
endmodule

// File: rtl/mload_chk.sv
module mload_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       st_rd,
    input logic       ram_we,
    input logic [1:0] ram_bank,
    input logic       zp_we,
    input logic [7:0] zp_addr,
    input logic       not_found
);
    // R6
    no_rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_bank != 2'd3));

    // R8
    zp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zp_we |-> (zp_addr == 8'hFE || zp_addr == 8'hFF || zp_addr == 8'h80));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R10
    activity_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd || ram_we || zp_we) |-> busy);

    // R9
    miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (!ram_we && !zp_we));
endmodule

bind mload_loader mload_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .st_rd    (st_rd),
    .ram_we   (ram_we),
    .ram_bank (ram_addr[RAM_AW-1 -: BANK_W]),
    .zp_we    (zp_we),
    .zp_addr  (zp_addr),
    .not_found(not_found)
);

// File: tb/sim_mload_loader.sv
`timescale 1ns/1ps
module sim_mload_loader;
    localparam int NIMG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        upper_rom = 1'b0;
    logic [7:0]  req_num = '0;
    logic        st_rd;
    logic [14:0] st_addr;
    logic [7:0]  st_data = '0;
    logic        ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        zp_we;
    logic [7:0]  zp_addr, zp_wdata;
    logic        busy, done, hdr_warn, page_warn, not_found;

    int vectors = 0;
    int misses  = 0;

    logic [7:0] hdr [NIMG][256];

    always #2 clk = ~clk;

    mload_loader #(.NUM_IMAGES(NIMG)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .upper_rom(upper_rom), .req_num(req_num), .st_rd(st_rd), .st_addr(st_addr),
        .st_data(st_data), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .zp_we(zp_we), .zp_addr(zp_addr), .zp_wdata(zp_wdata), .busy(busy), .done(done),
        .hdr_warn(hdr_warn), .page_warn(page_warn), .not_found(not_found)
    );

    function automatic logic [7:0] dbyte(input int img, input int off);
        return 8'((off * 7) + (img * 29) + (off >> 8));
    endfunction

    function automatic logic [7:0] sbyte(input int a);
        int img = a / 8448;
        int off = a % 8448;
        if (img >= NIMG) return 8'h00;
        if (off < 8192) return dbyte(img, off);
        return hdr[img][off - 8192];
    endfunction

    always @(posedge clk) if (st_rd) st_data <= sbyte(int'(st_addr));

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mk_hdr(input int i, input int num, input int np, input int seed,
                          input bit hbad, input int badpg);
        logic [7:0] s, d, ps;
        for (int k = 0; k < 256; k++) hdr[i][k] = 8'hFF;
        hdr[i][0] = 8'h0A + 8'(i); hdr[i][1] = 8'hF8; hdr[i][2] = 8'h30 + 8'(i);
        hdr[i][3] = 8'(np); hdr[i][4] = 8'h00; hdr[i][5] = 8'(num); hdr[i][6] = 8'h5A;
        s = 8'h00;
        for (int k = 0; k < 7; k++) s = s + hdr[i][k];
        hdr[i][7] = 8'h55 - s + (hbad ? 8'h01 : 8'h00);
        for (int j = 0; j < 32; j++) begin
            d = 8'hE0 | 8'(((j * 3) % 8) << 2) | 8'((j + seed) % 4);
            hdr[i][16 + j] = d;
            ps = 8'h00;
            for (int k = 0; k < 256; k++) ps = ps + dbyte(i, j * 256 + k);
            hdr[i][64 + j] = 8'h55 - ps - d - ((j == badpg) ? 8'h01 : 8'h00);
        end
    endtask

    // Reference model state, owned by the monitor
    int arm_seq = 0;
    logic [7:0] arm_req = '0;
    int seen_seq = 0;
    int cnt = 0;
    bit cur_busy = 0;
    bit e_hw = 0, e_pw = 0, e_nf = 0;
    int ram_q[$];
    int zp_q[$];
    int ram_wr_seen = 0;

    task automatic plan(input logic [7:0] req);
        int m = -1;
        int p;
        logic [7:0] hs, d, ps, b;
        ram_q.delete(); zp_q.delete(); ram_wr_seen = 0;
        for (int i = 0; i < NIMG; i++) if (m < 0 && hdr[i][5] == req) m = i;
        e_hw = 0; e_pw = 0; e_nf = 0;
        if (m < 0) begin
            e_nf = 1;
            cnt = 2 * NIMG + 1;
        end else begin
            hs = 8'h00;
            for (int k = 0; k < 8; k++) hs = hs + hdr[m][k];
            e_hw = (hs != 8'h55);
            p = (hdr[m][3] > 32) ? 32 : int'(hdr[m][3]);
            for (int j = 0; j < p; j++) begin
                d = hdr[m][16 + j];
                ps = d + hdr[m][64 + j];
                for (int k = 0; k < 256; k++) begin
                    b = dbyte(m, j * 256 + k);
                    ps = ps + b;
                    if (d[1:0] != 2'd3)
                        ram_q.push_back((((int'(d[1:0]) << 3 | int'(d[4:2])) << 8 | k) << 8) | int'(b));
                end
                if (ps != 8'h55) e_pw = 1;
            end
            zp_q.push_back({16'h0, 8'hFE, hdr[m][0]});
            zp_q.push_back({16'h0, 8'hFF, hdr[m][1]});
            zp_q.push_back({16'h0, 8'h80, hdr[m][2]});
            cnt = 2 * (m + 1) + 9 + 261 * p + 4;
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (seen_seq != arm_seq) begin
                seen_seq = arm_seq;
                plan(arm_req);
            end
            cur_busy = (cnt > 0);
            chk("R10 busy", int'(busy), int'(cur_busy));
            chk("R10 done", int'(done), int'(cnt == 1));
            if (ram_we) begin
                ram_wr_seen++;
                if (ram_q.size() == 0) chk("R6 stray ram write", 1, 0);
                else chk("R5 ram write", int'({ram_addr, ram_wdata}), ram_q.pop_front());
            end
            if (zp_we) begin
                if (zp_q.size() == 0) chk("R8 stray console write", 1, 0);
                else chk("R8 console write", int'({zp_addr, zp_wdata}), zp_q.pop_front());
            end
            if (!cur_busy || cnt == 1) begin
                chk("R3 hdr_warn", int'(hdr_warn), int'(e_hw));
                chk("R7 page_warn", int'(page_warn), int'(e_pw));
                chk("R9 not_found", int'(not_found), int'(e_nf));
            end
            if (cnt == 1) begin
                chk("R5 ram writes left", ram_q.size(), 0);
                chk("R8 console writes left", zp_q.size(), 0);
            end
            if (cnt > 0) cnt--;
        end
    end

    task automatic pulse(input logic [12:0] a, input bit rom, input bit rd, input logic [7:0] req);
        @(negedge clk);
        bus_addr = a; upper_rom = rom; bus_rd = rd; req_num = req;
        if (rd && rom && a == 13'h1850 && !cur_busy) begin
            arm_req = req;
            arm_seq++;
        end
        @(negedge clk);
        bus_rd = 1'b0; upper_rom = 1'b0; bus_addr = '0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (cur_busy || seen_seq != arm_seq);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        mk_hdr(0, 7, 2, 0, 0, -1);
        mk_hdr(1, 9, 3, 2, 1, -1);
        mk_hdr(2, 9, 4, 1, 0, -1);
        repeat (4) @(negedge clk);
        #1;
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 flags", int'({hdr_warn, page_warn, not_found}), 0);
        chk("R11 strobes", int'({st_rd, ram_we, zp_we}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 near-miss triggers are ignored
        pulse(13'h1851, 1, 1, 8'd7);
        pulse(13'h1850, 0, 1, 8'd7);
        pulse(13'h1850, 1, 0, 8'd7);
        repeat (5) @(negedge clk);
        chk("R1 no start", int'(busy), 0);

        // R2 R5 R8 plain load from image 0
        pulse(13'h1850, 1, 1, 8'd7);
        wait_idle();
        chk("R2 image 0 fully written", ram_q.size(), 0);

        // R2 first match among duplicates, R3 bad header, R6 bank 3 skipped
        pulse(13'h1850, 1, 1, 8'd9);
        wait_idle();
        chk("R2 first duplicate chosen", ram_wr_seen, 2 * 256);

        // R7 one bad page stays flagged
        mk_hdr(2, 12, 4, 1, 0, 1);
        pulse(13'h1850, 1, 1, 8'd12);
        wait_idle();

        // R10 flags cleared by a clean load
        pulse(13'h1850, 1, 1, 8'd7);
        wait_idle();
        chk("R10 flags cleared", int'({hdr_warn, page_warn}), 0);

        // R9 no matching image
        pulse(13'h1850, 1, 1, 8'd99);
        wait_idle();
        chk("R9 no writes", ram_wr_seen, 0);

        // R4 zero pages
        mk_hdr(0, 7, 0, 0, 0, -1);
        pulse(13'h1850, 1, 1, 8'd7);
        wait_idle();
        chk("R4 zero pages", ram_wr_seen, 0);

        // R4 count capped at 32 (8 of 32 descriptors name bank 3)
        mk_hdr(0, 7, 40, 0, 0, -1);
        pulse(13'h1850, 1, 1, 8'd7);
        wait_idle();
        chk("R4 capped count", ram_wr_seen, 24 * 256);

        // R1 valid trigger during a load is ignored
        mk_hdr(0, 7, 2, 0, 0, -1);
        pulse(13'h1850, 1, 1, 8'd12);
        repeat (100) @(negedge clk);
        pulse(13'h1850, 1, 1, 8'd7);
        wait_idle();
        chk("R1 retrigger ignored", ram_wr_seen, 3 * 256);

        summary();
        $finish;
    end
endmodule